// File: doc/BRIEF.md
# Power-On Reset Time-Out Sequencer

This block keeps a processor core in reset after power-up until its clocks can be trusted. After the power-on pulse ends, it runs up to three timed waits in a fixed order. The first is a power-up delay counted on a slow internal tick. The second is an oscillator settling wait counted on main-clock cycles. The third is a PLL lock wait counted on the slow tick. Each wait is skipped when the configuration does not need it.

The waits start from the power-on pulse, not from the external reset pin. If the pin is held low until every wait has expired, the core leaves reset as soon as the synchronized pin goes high. A wake request from a clock-stopped low-power state re-runs only the oscillator and PLL waits. A new power-on pulse at any time restarts the whole sequence.

All logic runs on the main clock. The slow internal clock arrives as a one-cycle enable pulse, `lf_tick`. The configuration inputs are plain levels, and the block has no data stream. Phase lengths are parameters so that simulation can use short values.

Top module: `por_timeout_seq`

## Requirements
- R1: While `por_pulse` is high, `core_rst` is high. After it falls, the sequence begins at the first enabled phase, with every counter cleared.
- R2: The power-up phase (phase code 1) runs only when `pwrt_en_n` is 0. It lasts exactly 2**PWRT_W `lf_tick` pulses.
- R3: The oscillator phase (phase code 2) runs only for crystal or resonator modes, where `osc_mode` is 00, 01 or 10; mode 11 is RC. It lasts exactly OST_CYCLES clock cycles.
- R4: The PLL phase (phase code 3) runs only when `pll_en` is 1. It lasts exactly PLL_TICKS `lf_tick` pulses.
- R5: Enabled phases always run in the order power-up, oscillator, PLL, then code 0 (done). A disabled phase is skipped.
- R6: With RC mode, `pwrt_en_n` = 1 and `pll_en` = 0, no phase runs. `phase` reads 0 and `core_rst` is low in the first cycle in which `por_pulse` is low.
- R7: `core_rst` is high whenever `phase` is not 0.
- R8: The phases run while `mclr_n` is low, and `core_rst` stays high while the synchronized pin is low. Once all phases are done, `core_rst` falls exactly MCLR_STAGES clock edges after `mclr_n` rises.
- R9: In the done state, a `wake_req` pulse starts the oscillator phase and skips the power-up phase. In non-crystal modes it starts the PLL phase instead. It has no effect in RC mode when `pll_en` is 0.
- R10: A `wake_req` pulse while a phase is running is ignored. Phase lengths and order are unchanged.
- R11: A `por_pulse` during any phase restarts the sequence from the power-up phase, with full phase lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| por_pulse | input | 1 | Power-on reset pulse, active high, synchronous clear |
| mclr_n | input | 1 | External master reset pin, active low, asynchronous |
| lf_tick | input | 1 | One-cycle enable marking each slow internal clock tick |
| osc_mode | input | 2 | Oscillator mode: 00/01/10 crystal or resonator, 11 RC |
| pll_en | input | 1 | PLL enabled |
| pwrt_en_n | input | 1 | Power-up delay enable, active low |
| wake_req | input | 1 | Wake from a low-power state that stopped the oscillator |
| core_rst | output | 1 | Reset to the core, active high |
| phase | output | 2 | Active phase: 0 done, 1 power-up, 2 oscillator, 3 PLL |

## Verification
The assertions assume that `osc_mode`, `pll_en` and `pwrt_en_n` change only while `por_pulse` is high. They also assume `por_pulse` is high from time zero, so the state is cleared before any check becomes active. The bench follows both rules: it changes the configuration only inside a power-on pulse that lasts several cycles, and it starts with that pulse asserted. `lf_tick` comes from a fixed divider and is never high for two cycles in a row. Wake pulses last one cycle, as the block expects.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

  typedef enum logic [1:0] {
    PH_DONE = 2'd0,
    PH_PWRT = 2'd1,
    PH_OST  = 2'd2,
    PH_PLL  = 2'd3
  } phase_e;

  localparam logic [1:0] MODE_RC = 2'b11;

  // Phase that follows cur once it finishes, skipping phases that are off.
  function automatic phase_e after_phase(phase_e cur, logic xtal, logic pll);
    phase_e nxt;
    nxt = PH_DONE;
    case (cur)
      PH_PWRT: nxt = xtal ? PH_OST : (pll ? PH_PLL : PH_DONE);
      PH_OST:  nxt = pll ? PH_PLL : PH_DONE;
      default: nxt = PH_DONE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/por_phase_timer.sv
module por_phase_timer #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic clr,
  input  logic step,
  output logic done
);
  localparam int unsigned W = (LEN > 2) ? $clog2(LEN) : 1;
  localparam logic [W-1:0] LAST = W'(LEN - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr)       cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + 1'b1;
  end

  assign done = !clr && step && (cnt_q == LAST);
endmodule

// File: rtl/por_pin_sync.sv
module por_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic pin_n,
  output logic sync_n
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) sh_q <= pin_n;
    end else begin : g_chain
      always_ff @(posedge clk) sh_q <= {sh_q[STAGES-2:0], pin_n};
    end
  endgenerate

  assign sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/por_timeout_seq.sv
module por_timeout_seq
  import por_seq_pkg::*;
#(
  parameter int unsigned PWRT_W      = 11,
  parameter int unsigned OST_CYCLES  = 1024,
  parameter int unsigned PLL_TICKS   = 63,
  parameter int unsigned MCLR_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_pulse,
  input  logic       mclr_n,
  input  logic       lf_tick,
  input  logic [1:0] osc_mode,
  input  logic       pll_en,
  input  logic       pwrt_en_n,
  input  logic       wake_req,
  output logic       core_rst,
  output logic [1:0] phase
);
  localparam int unsigned PWRT_TICKS = 1 << PWRT_W;

  phase_e phase_q, phase_d, first_ph;
  logic   xtal_mode, pin_sync_n;
  logic   pwrt_done, ost_done, pll_done;

  assign xtal_mode = (osc_mode != MODE_RC);
  assign first_ph  = after_phase(PH_PWRT, xtal_mode, pll_en);

  por_phase_timer #(.LEN(PWRT_TICKS)) u_pwrt_tmr (
    .clk (clk),
    .clr (por_pulse || (phase_q != PH_PWRT)),
    .step(lf_tick),
    .done(pwrt_done)
  );

  por_phase_timer #(.LEN(OST_CYCLES)) u_ost_tmr (
    .clk (clk),
    .clr (por_pulse || (phase_q != PH_OST)),
    .step(1'b1),
    .done(ost_done)
  );

  por_phase_timer #(.LEN(PLL_TICKS)) u_pll_tmr (
    .clk (clk),
    .clr (por_pulse || (phase_q != PH_PLL)),
    .step(lf_tick),
    .done(pll_done)
  );

  por_pin_sync #(.STAGES(MCLR_STAGES)) u_pin_sync (
    .clk   (clk),
    .pin_n (mclr_n),
    .sync_n(pin_sync_n)
  );

  always_comb begin
    phase_d = phase_q;
    if (por_pulse) begin
      phase_d = pwrt_en_n ? first_ph : PH_PWRT;
    end else begin
      case (phase_q)
        PH_PWRT: if (pwrt_done) phase_d = after_phase(PH_PWRT, xtal_mode, pll_en);
        PH_OST:  if (ost_done)  phase_d = after_phase(PH_OST, xtal_mode, pll_en);
        PH_PLL:  if (pll_done)  phase_d = PH_DONE;
        default: if (wake_req)  phase_d = first_ph;
      endcase
    end
  end

  always_ff @(posedge clk) phase_q <= phase_d;

  assign phase    = phase_q;
  assign core_rst = por_pulse || !pin_sync_n || (phase_q != PH_DONE);
endmodule

// File: rtl/por_timeout_seq_chk.sv
module por_timeout_seq_chk
  import por_seq_pkg::*;
(
  input logic       clk,
  input logic       por_pulse,
  input logic       mclr_n,
  input logic       lf_tick,
  input logic [1:0] osc_mode,
  input logic       pll_en,
  input logic       pwrt_en_n,
  input logic       core_rst,
  input logic [1:0] phase
);
  AST_POR_HOLDS_RST: assert property (@(posedge clk)
    por_pulse |-> core_rst); // R1

  AST_PWRT_WAITS_TICK: assert property (@(posedge clk) disable iff (por_pulse)
    (phase == PH_PWRT && !lf_tick) |=> (phase == PH_PWRT)); // R2

  AST_NO_PWRT_WHEN_OFF: assert property (@(posedge clk) disable iff (por_pulse)
    pwrt_en_n |-> (phase != PH_PWRT)); // R2

  AST_NO_OST_IN_RC: assert property (@(posedge clk) disable iff (por_pulse)
    (osc_mode == MODE_RC) |-> (phase != PH_OST)); // R3

  AST_PLL_WAITS_TICK: assert property (@(posedge clk) disable iff (por_pulse)
    (phase == PH_PLL && !lf_tick) |=> (phase == PH_PLL)); // R4

  AST_NO_PLL_WHEN_OFF: assert property (@(posedge clk) disable iff (por_pulse)
    !pll_en |-> (phase != PH_PLL)); // R4

  AST_OST_FOLLOWER: assert property (@(posedge clk) disable iff (por_pulse)
    (!$past(por_pulse) && $past(phase) == PH_OST && phase != PH_OST)
      |-> (phase == PH_PLL || phase == PH_DONE)); // R5

  AST_BUSY_HOLDS_RST: assert property (@(posedge clk) disable iff (por_pulse)
    (phase != PH_DONE) |-> core_rst); // R7

  AST_PIN_HOLDS_RST: assert property (@(posedge clk) disable iff (por_pulse)
    !mclr_n |=> ##1 core_rst); // R8
endmodule

bind por_timeout_seq por_timeout_seq_chk u_chk (
  .clk      (clk),
  .por_pulse(por_pulse),
  .mclr_n   (mclr_n),
  .lf_tick  (lf_tick),
  .osc_mode (osc_mode),
  .pll_en   (pll_en),
  .pwrt_en_n(pwrt_en_n),
  .core_rst (core_rst),
  .phase    (phase)
);

// File: tb/por_timeout_seq_tb.sv
module por_timeout_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PWRT_W     = 3;
  localparam int OST_CYC    = 10;
  localparam int PLL_TK     = 4;
  localparam int STAGES     = 2;
  localparam int LF_DIV     = 3;

  logic       clk = 1'b0;
  logic       por_pulse = 1'b1;
  logic       mclr_n = 1'b1;
  logic       lf_tick = 1'b0;
  logic [1:0] osc_mode = 2'b00;
  logic       pll_en = 1'b0;
  logic       pwrt_en_n = 1'b0;
  logic       wake_req = 1'b0;
  logic       core_rst;
  logic [1:0] phase;

  int n_chk = 0;
  int n_err = 0;
  int div_q = 0;
  int m_pwrt, m_ost, m_pll, m_trace, m_busy_bad, m_rst_done, m_done;

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    div_q   <= (div_q == LF_DIV - 1) ? 0 : div_q + 1;
    lf_tick <= (div_q == LF_DIV - 1);
  end

  por_timeout_seq #(
    .PWRT_W(PWRT_W), .OST_CYCLES(OST_CYC), .PLL_TICKS(PLL_TK), .MCLR_STAGES(STAGES)
  ) u_dut (
    .clk(clk), .por_pulse(por_pulse), .mclr_n(mclr_n), .lf_tick(lf_tick),
    .osc_mode(osc_mode), .pll_en(pll_en), .pwrt_en_n(pwrt_en_n),
    .wake_req(wake_req), .core_rst(core_rst), .phase(phase)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_trace(input bit pw, input bit xt, input bit pl);
    int t;
    t = 0;
    if (pw) t = t * 4 + 1;
    if (xt) t = t * 4 + 2;
    if (pl) t = t * 4 + 3;
    return t * 4;
  endfunction

  task automatic do_por(input logic [1:0] md, input bit pl, input bit pwn, input bit pin);
    @(negedge clk); #1;
    por_pulse <= 1'b1;
    osc_mode  <= md;
    pll_en    <= pl;
    pwrt_en_n <= pwn;
    mclr_n    <= pin;
    repeat (3) begin @(negedge clk); #1; end
    chk("R1 reset holds core_rst", int'(core_rst), 1);
    por_pulse <= 1'b0;
  endtask

  task automatic measure(input int wake_at);
    int last;
    m_pwrt = 0; m_ost = 0; m_pll = 0; m_trace = 0;
    m_busy_bad = 0; m_rst_done = -1; m_done = 0;
    last = -1;
    #1;
    for (int k = 0; k < 2000; k++) begin
      wake_req <= (k == wake_at);
      if (int'(phase) != last) begin
        m_trace = m_trace * 4 + int'(phase);
        last = int'(phase);
      end
      if (phase == 2'd0) begin
        m_rst_done = int'(core_rst);
        m_done = 1;
        break;
      end
      if (!core_rst) m_busy_bad++;
      case (phase)
        2'd1: if (lf_tick) m_pwrt++;
        2'd2: m_ost++;
        2'd3: if (lf_tick) m_pll++;
        default: ;
      endcase
      @(negedge clk); #1;
    end
    wake_req <= 1'b0;
    chk("R5 sequence completes", m_done, 1);
    chk("R7 core_rst high while busy", m_busy_bad, 0);
  endtask

  task automatic pulse_wake();
    @(negedge clk); #1;
    wake_req <= 1'b1;
    @(negedge clk); #1;
    wake_req <= 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // Full sweep of configurations: R2 R3 R4 R5 R6
    for (int c = 0; c < 16; c++) begin
      bit [1:0] md;
      bit pl, pwn, xt;
      md  = c[1:0];
      pl  = c[2];
      pwn = c[3];
      xt  = (md != 2'b11);
      do_por(md, pl, pwn, 1'b1);
      measure(-1);
      chk("R2 power-up tick count", m_pwrt, pwn ? 0 : (1 << PWRT_W));
      chk("R3 oscillator cycle count", m_ost, xt ? OST_CYC : 0);
      chk("R4 PLL tick count", m_pll, pl ? PLL_TK : 0);
      chk("R5 phase order", m_trace, exp_trace(!pwn, xt, pl));
      chk("R6 core_rst low once done", m_rst_done, 0);
    end

    // R6: empty sequence releases in the first cycle after the pulse
    do_por(2'b11, 1'b0, 1'b1, 1'b1);
    #1;
    chk("R6 phase done at once", int'(phase), 0);
    chk("R6 core_rst low at once", int'(core_rst), 0);

    // R8: the time-outs run under a held pin; release after STAGES edges
    do_por(2'b10, 1'b1, 1'b0, 1'b0);
    measure(-1);
    chk("R8 power-up ran under pin", m_pwrt, 1 << PWRT_W);
    chk("R8 oscillator ran under pin", m_ost, OST_CYC);
    chk("R8 held while pin low", m_rst_done, 1);
    repeat (5) begin @(negedge clk); #1; end
    chk("R8 still held after wait", int'(core_rst), 1);
    mclr_n <= 1'b1;
    for (int e = 1; e <= STAGES; e++) begin
      @(negedge clk); #1;
      chk("R8 release edge", int'(core_rst), (e == STAGES) ? 0 : 1);
    end

    // R9: wake from done, crystal with PLL
    do_por(2'b01, 1'b1, 1'b0, 1'b1);
    measure(-1);
    pulse_wake();
    measure(-1);
    chk("R9 wake skips power-up", m_pwrt, 0);
    chk("R9 wake oscillator count", m_ost, OST_CYC);
    chk("R9 wake PLL count", m_pll, PLL_TK);
    chk("R9 wake order", m_trace, exp_trace(1'b0, 1'b1, 1'b1));

    // R9: wake in RC mode with PLL on relocks only
    do_por(2'b11, 1'b1, 1'b1, 1'b1);
    measure(-1);
    pulse_wake();
    measure(-1);
    chk("R9 RC wake order", m_trace, exp_trace(1'b0, 1'b0, 1'b1));

    // R9: wake in RC mode with PLL off has no effect
    do_por(2'b11, 1'b0, 1'b1, 1'b1);
    measure(-1);
    pulse_wake();
    repeat (3) begin
      chk("R9 RC no-PLL wake phase", int'(phase), 0);
      chk("R9 RC no-PLL wake core_rst", int'(core_rst), 0);
      @(negedge clk); #1;
    end

    // R10: wake pulses during power-up and oscillator phases are ignored
    for (int w = 2; w <= 30; w += 14) begin
      do_por(2'b00, 1'b1, 1'b0, 1'b1);
      measure(w);
      chk("R10 busy wake power-up count", m_pwrt, 1 << PWRT_W);
      chk("R10 busy wake oscillator count", m_ost, OST_CYC);
      chk("R10 busy wake order", m_trace, exp_trace(1'b1, 1'b1, 1'b1));
    end

    // R11: a power-on pulse during the oscillator phase restarts everything
    do_por(2'b10, 1'b1, 1'b0, 1'b1);
    #1;
    for (int k = 0; k < 500 && phase != 2'd2; k++) begin @(negedge clk); #1; end
    chk("R11 reached oscillator phase", int'(phase), 2);
    repeat (3) @(negedge clk);
    #1;
    por_pulse <= 1'b1;
    @(negedge clk); #1;
    chk("R11 restart phase", int'(phase), 1);
    por_pulse <= 1'b0;
    measure(-1);
    chk("R11 full power-up count", m_pwrt, 1 << PWRT_W);
    chk("R11 full oscillator count", m_ost, OST_CYC);
    chk("R11 full PLL count", m_pll, PLL_TK);
    chk("R11 order after restart", m_trace, exp_trace(1'b1, 1'b1, 1'b1));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule